// File: doc/BRIEF.md
# Load-Use Hazard Stall Controller

This block keeps an in-order five-stage pipeline correct when an instruction in decode reads a register that a load, now one stage ahead in execute, has not yet fetched from memory. It compares the destination index of the load against both source indices of the decoding instruction. On a match it freezes the program counter and the fetch/decode latch for one cycle. For that cycle it also sends an all-zero control word into the execute latch, so the slot carries no memory access, no register write and ALU code 00.

The hazard decision is purely combinational: four inputs give three control outputs. It is wrapped with the program counter, the fetch/decode latch and the control/destination part of the decode/execute latch, so that the stall and its recovery can be seen at the ports. Branch handling and operand forwarding are not part of this block. After the single stall cycle, the forwarding path from the memory/writeback latch is expected to supply the loaded value.

Top module: `lus_stall_top`

## Requirements
- R1: The control word is 5 bits, {mem_read[4], mem_write[3], reg_write[2], alu_op[1:0]}. A stall is raised exactly when the execute-stage word has mem_read set and its destination index equals the decoding instruction's first or second source index. A stall shows as pc_we=0, ifid_we=0 and bubble_sel=1. With no stall these read 1, 1 and 0.
- R2: In a stall cycle the program counter keeps its value, so the same address is fetched again.
- R3: In a stall cycle the fetch/decode latch keeps its contents, so the same instruction is decoded again.
- R4: In a stall cycle the control word entering the execute latch is all zero. The cycle after a stall therefore shows ex_ctl = 5'b00000.
- R5: A stall never lasts more than one cycle. The bubble has mem_read clear, so the repeated instruction does not stall again.
- R6: In a cycle with no stall the program counter advances by 4, and the fetched fields enter the fetch/decode latch.
- R7: A synchronous active-high reset sets the program counter to 0, loads a no-op (indices 0, control 0) into the fetch/decode latch and clears the execute latch.
- R8: A load whose destination is register 0 still stalls when a source index of the decoding instruction is 0.
- R9: A load followed by a dependent load, or by an instruction whose two sources both match, stalls exactly once.
- R10: A store or ALU operation in execute (mem_read clear) never stalls, even when its destination index matches a source of the decoding instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_rs | input | RW | First source index of the instruction at pc_out |
| fetch_rt | input | RW | Second source / load destination index of the instruction at pc_out |
| fetch_ctl | input | 5 | Decoded control word of the instruction at pc_out |
| pc_out | output | XLEN | Program counter |
| pc_we | output | 1 | Program counter write enable |
| ifid_we | output | 1 | Fetch/decode latch write enable |
| bubble_sel | output | 1 | Forces the control word into execute to zero |
| dec_rs | output | RW | First source index held in decode |
| dec_rt | output | RW | Second source index held in decode |
| ex_ctl | output | 5 | Control word held in execute |
| ex_rt | output | RW | Destination index held in execute |

## Verification
The stall flags are combinational from the decode and execute latches. They are therefore due in the same cycle in which a load and its dependent sit in adjacent stages, which is one edge after the dependent instruction was fetched. The program counter and decode fields respond one edge after the flags, and the zeroed control word is visible in execute one edge after the stall. The bench builds the expected decode stream for a whole program, with each dependent instruction duplicated, and derives from it one expected item per cycle. It samples every item at the falling edge, after all the registers on the path have settled.

// File: rtl/lus_pkg.sv
package lus_pkg;
  typedef struct packed {
    logic       mem_read;
    logic       mem_write;
    logic       reg_write;
    logic [1:0] alu_op;
  } ctl_t;

  localparam int CTL_W = $bits(ctl_t);
endpackage

// File: rtl/lus_detect.sv
module lus_detect #(
  parameter int RW = 5
) (
  input  logic          ex_mem_read,
  input  logic [RW-1:0] ex_rt,
  input  logic [RW-1:0] dec_rs,
  input  logic [RW-1:0] dec_rt,
  output logic          pc_we,
  output logic          ifid_we,
  output logic          bubble_sel
);
  logic hit;

  always_comb begin
    hit        = ex_mem_read && ((ex_rt == dec_rs) || (ex_rt == dec_rt));
    pc_we      = !hit;
    ifid_we    = !hit;
    bubble_sel = hit;
  end
endmodule

// File: rtl/lus_front.sv
module lus_front
  import lus_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int RW   = 5,
  parameter int STEP = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            pc_we,
  input  logic            ifid_we,
  input  logic [RW-1:0]   fetch_rs,
  input  logic [RW-1:0]   fetch_rt,
  input  ctl_t            fetch_ctl,
  output logic [XLEN-1:0] pc,
  output logic [RW-1:0]   dec_rs,
  output logic [RW-1:0]   dec_rt,
  output ctl_t            dec_ctl
);
  localparam logic [XLEN-1:0] PC_INC = XLEN'(STEP);

  always_ff @(posedge clk) begin
    if (rst) begin
      pc <= '0;
    end else if (pc_we) begin
      pc <= pc + PC_INC;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_rs  <= '0;
      dec_rt  <= '0;
      dec_ctl <= '0;
    end else if (ifid_we) begin
      dec_rs  <= fetch_rs;
      dec_rt  <= fetch_rt;
      dec_ctl <= fetch_ctl;
    end
  end

  p_pc_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !pc_we |=> $stable(pc));
  p_pc_step_r6: assert property (@(posedge clk) disable iff (rst)
    pc_we |=> pc == $past(pc) + PC_INC);
  p_ifid_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !ifid_we |=> ($stable(dec_rs) && $stable(dec_rt) && $stable(dec_ctl)));
  p_ifid_load_r6: assert property (@(posedge clk) disable iff (rst)
    ifid_we |=> dec_rs == $past(fetch_rs));
endmodule

// File: rtl/lus_exlatch.sv
module lus_exlatch
  import lus_pkg::*;
#(
  parameter int RW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bubble_sel,
  input  ctl_t          dec_ctl,
  input  logic [RW-1:0] dec_rt,
  output ctl_t          ex_ctl,
  output logic [RW-1:0] ex_rt
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ex_ctl <= '0;
      ex_rt  <= '0;
    end else begin
      ex_ctl <= bubble_sel ? ctl_t'('0) : dec_ctl;
      ex_rt  <= dec_rt;
    end
  end

  p_bubble_zero_r4: assert property (@(posedge clk) disable iff (rst)
    bubble_sel |=> ex_ctl == '0);
  p_pass_ctl_r4: assert property (@(posedge clk) disable iff (rst)
    !bubble_sel |=> ex_ctl == $past(dec_ctl));
endmodule

// File: rtl/lus_stall_top.sv
module lus_stall_top
  import lus_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int RW   = 5,
  parameter int STEP = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [RW-1:0]    fetch_rs,
  input  logic [RW-1:0]    fetch_rt,
  input  logic [CTL_W-1:0] fetch_ctl,
  output logic [XLEN-1:0]  pc_out,
  output logic             pc_we,
  output logic             ifid_we,
  output logic             bubble_sel,
  output logic [RW-1:0]    dec_rs,
  output logic [RW-1:0]    dec_rt,
  output logic [CTL_W-1:0] ex_ctl,
  output logic [RW-1:0]    ex_rt
);
  ctl_t dec_ctl_s;
  ctl_t ex_ctl_s;

  lus_front #(.XLEN(XLEN), .RW(RW), .STEP(STEP)) u_front (
    .clk       (clk),
    .rst       (rst),
    .pc_we     (pc_we),
    .ifid_we   (ifid_we),
    .fetch_rs  (fetch_rs),
    .fetch_rt  (fetch_rt),
    .fetch_ctl (ctl_t'(fetch_ctl)),
    .pc        (pc_out),
    .dec_rs    (dec_rs),
    .dec_rt    (dec_rt),
    .dec_ctl   (dec_ctl_s)
  );

  lus_detect #(.RW(RW)) u_detect (
    .ex_mem_read (ex_ctl_s.mem_read),
    .ex_rt       (ex_rt),
    .dec_rs      (dec_rs),
    .dec_rt      (dec_rt),
    .pc_we       (pc_we),
    .ifid_we     (ifid_we),
    .bubble_sel  (bubble_sel)
  );

  lus_exlatch #(.RW(RW)) u_ex (
    .clk        (clk),
    .rst        (rst),
    .bubble_sel (bubble_sel),
    .dec_ctl    (dec_ctl_s),
    .dec_rt     (dec_rt),
    .ex_ctl     (ex_ctl_s),
    .ex_rt      (ex_rt)
  );

  assign ex_ctl = ex_ctl_s;

  p_single_stall_r5: assert property (@(posedge clk) disable iff (rst)
    bubble_sel |=> !bubble_sel);
  p_no_stall_nonload_r10: assert property (@(posedge clk) disable iff (rst)
    !ex_ctl_s.mem_read |-> pc_we);
  p_reset_state_r7: assert property (@(posedge clk)
    rst |=> (pc_out == '0 && ex_ctl == '0 && dec_rs == '0 && dec_rt == '0));
endmodule

// File: tb/lus_stall_top_bench.sv
module lus_stall_top_bench;
  localparam int XLEN = 32;
  localparam int RW   = 5;
  localparam int NP   = 14;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [RW-1:0]   fetch_rs = '0;
  logic [RW-1:0]   fetch_rt = '0;
  logic [4:0]      fetch_ctl = '0;
  logic [XLEN-1:0] pc_out;
  logic            pc_we, ifid_we, bubble_sel;
  logic [RW-1:0]   dec_rs, dec_rt, ex_rt;
  logic [4:0]      ex_ctl;

  always #2 clk = ~clk;

  lus_stall_top #(.XLEN(XLEN), .RW(RW), .STEP(4)) u_lus_stall_top (
    .clk(clk), .rst(rst), .fetch_rs(fetch_rs), .fetch_rt(fetch_rt),
    .fetch_ctl(fetch_ctl), .pc_out(pc_out), .pc_we(pc_we), .ifid_we(ifid_we),
    .bubble_sel(bubble_sel), .dec_rs(dec_rs), .dec_rt(dec_rt),
    .ex_ctl(ex_ctl), .ex_rt(ex_rt)
  );

  localparam logic [4:0] LD = 5'b10100;
  localparam logic [4:0] AL = 5'b00110;
  localparam logic [4:0] ST = 5'b01000;

  logic [4:0]    p_ctl [NP] = '{LD, AL, AL, LD, AL, LD, AL, LD, LD, AL, ST, LD, AL, ST};
  logic [RW-1:0] p_rs  [NP] = '{1, 2, 2, 3, 4, 9, 0, 1, 8, 9, 10, 11, 13, 5};
  logic [RW-1:0] p_rt  [NP] = '{2, 5, 6, 7, 7, 0, 3, 8, 9, 9, 11, 12, 14, 12};

  typedef struct {
    logic [XLEN-1:0] pc;
    logic            stall;
    logic [4:0]      ctl;
    logic [RW-1:0]   rs;
    logic [RW-1:0]   rt;
    int              idx;
  } item_t;

  item_t exp_q[$];
  int    checks = 0;
  int    fails  = 0;
  bit    done   = 1'b0;

  function automatic bit dep(int i);
    if (i <= 0 || i >= NP) return 1'b0;
    return p_ctl[i-1][4] && (p_rt[i-1] == p_rs[i] || p_rt[i-1] == p_rt[i]);
  endfunction

  function automatic string tag_of(int i);
    if (i == 6) return "R8";
    if (i == 8 || i == 9) return "R9";
    if (i == 11) return "R10";
    return "R1";
  endfunction

  task automatic push_expected();
    int    ds[$];
    bit    st[$];
    int    nst = 0;
    item_t it;
    ds.push_back(-1); st.push_back(1'b0);
    for (int i = 0; i < NP + 3; i++) begin
      if (dep(i)) begin ds.push_back(i); st.push_back(1'b1); end
      ds.push_back(i); st.push_back(1'b0);
    end
    for (int t = 0; t < ds.size(); t++) begin
      it.idx   = ds[t];
      it.pc    = XLEN'(4 * (t - nst));
      it.stall = st[t];
      it.rs    = (ds[t] >= 0 && ds[t] < NP) ? p_rs[ds[t]] : '0;
      it.rt    = (ds[t] >= 0 && ds[t] < NP) ? p_rt[ds[t]] : '0;
      if (t == 0 || st[t-1]) it.ctl = '0;
      else it.ctl = (ds[t-1] >= 0 && ds[t-1] < NP) ? p_ctl[ds[t-1]] : '0;
      exp_q.push_back(it);
      if (st[t]) nst++;
    end
  endtask

  task automatic chk(bit ok, string req, string what, longint act, longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  task automatic drive_fetch();
    int k = int'(pc_out >> 2);
    if (k < NP) begin
      fetch_rs = p_rs[k]; fetch_rt = p_rt[k]; fetch_ctl = p_ctl[k];
    end else begin
      fetch_rs = '0; fetch_rt = '0; fetch_ctl = '0;
    end
  endtask

  task automatic monitor();
    item_t e;
    bit    prev_stall = 1'b0;
    while (exp_q.size() > 0) begin
      e = exp_q.pop_front();
      chk(pc_out == e.pc, prev_stall ? "R2" : "R6", "pc", pc_out, e.pc);
      chk(bubble_sel == e.stall && pc_we == !e.stall && ifid_we == !e.stall,
          tag_of(e.idx), "stall", {bubble_sel, pc_we, ifid_we},
          {e.stall, !e.stall, !e.stall});
      chk(ex_ctl == e.ctl, prev_stall ? "R4" : "R6", "ex_ctl", ex_ctl, e.ctl);
      chk(dec_rs == e.rs && dec_rt == e.rt, prev_stall ? "R3" : "R6",
          "dec_fields", {dec_rs, dec_rt}, {e.rs, e.rt});
      if (prev_stall) chk(!bubble_sel, "R5", "repeat_stall", bubble_sel, 0);
      prev_stall = e.stall;
      drive_fetch();
      @(negedge clk);
    end
  endtask

  initial begin
    push_expected();
    repeat (3) @(negedge clk);
    chk(pc_out == '0 && ex_ctl == '0 && dec_rs == '0 && dec_rt == '0,
        "R7", "reset_state", {pc_out[7:0], ex_ctl, dec_rs, dec_rt}, 0);
    rst = 1'b0;
    monitor();
    rst = 1'b1;
    @(negedge clk);
    chk(pc_out == '0 && ex_ctl == '0, "R7", "reset_again", pc_out, 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule